// File: doc/BRIEF.md
# Hysteretic protection fault monitor

This block watches the sampled health measurements of a battery pack and keeps a 13-bit fault word. The measurements are the highest and lowest cell voltage, the pack voltage, signed pack current, and the charge-side and discharge-side temperatures. Eight voltage and temperature faults use two thresholds each. A fault trips when the value goes past its trip threshold. It is held until the value has crossed back past a separate release threshold and then stays there for a programmable number of one-second ticks. Overcurrent faults also need the condition to hold for a programmable number of ticks before they trip.

From the fault word the block derives two permit outputs, one for the charge switch and one for the discharge switch. Configuration can force either switch off. A saturating event counter is kept for each of the eleven protection faults, and a clear strobe zeroes all of them. All delays advance only on the one-second tick input. The measurements, thresholds and delays are plain inputs sampled every clock.

Top module: `prot_fault_mon`

## Requirements
- R1: Status bits: 0 cell over-voltage (max cell), 1 cell under-voltage (min cell), 2 pack over-voltage, 3 pack under-voltage, 4 charge over-temperature, 5 charge under-temperature, 6 discharge over-temperature, 7 discharge under-temperature, 8 charge overcurrent, 9 discharge overcurrent, 10 short circuit, 11 front-end error, 12 switch locked by configuration. Trip threshold k lives at `trip_thr_i[16k+:16]`. An over fault (even k) sets when value > trip and an under fault (odd k) sets when value < trip. The bit is visible one clock after the sampling edge.
- R2: A set over fault is held while value >= its release threshold (`rel_thr_i[16k+:16]`). A set under fault is held while value <= its release threshold.
- R3: `pair_dly_i[16p+:16]` serves pair p (0 cell, 1 pack, 2 charge temp, 3 discharge temp). Its low byte is the release delay of the under fault and its high byte that of the over fault. Once a fault is past its release threshold, it clears after that many ticks have been counted there. A delay of 0 clears it at the first edge past release.
- R4: A re-trip, or a return into the band between the release and trip thresholds, while a fault is set reloads its full release delay.
- R5: Current is signed in two's complement. Charge overcurrent trips when current > `oc_chg_thr_i`, and discharge overcurrent when current < `oc_dsg_thr_i`. The condition must hold for the trip delay (low byte of the delay port) in ticks. The fault releases after the release delay (high byte) counted with the current back within the threshold.
- R6: Bit 10 follows `short_det_i` with trip delay 0 and release delay `sc_rel_dly_i`. Bit 11 is `afe_fault_i` registered one clock.
- R7: `fet_off_i[0]` blocks charge and `fet_off_i[1]` blocks discharge. Either bit sets status bit 12 one clock later.
- R8: `chg_en_o` is low when any of status bits 0, 2, 4, 5, 8 or 10 is set or the charge switch is blocked. `dsg_en_o` is low when any of bits 1, 3, 6, 7, 9 or 10 is set or the discharge switch is blocked.
- R9: Counter k (`evt_cnt_o[k*CNT_W+:CNT_W]`, k = 0..10) increments on the edge where status bit k sets and saturates at all ones.
- R10: `cnt_clr_i` zeroes every counter. A fault setting at the same edge as the clear leaves its counter at 1.
- R11: After reset the status word and counters are zero and both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one clock wide |
| cell_max_i | input | W | Highest cell voltage, 1 mV |
| cell_min_i | input | W | Lowest cell voltage, 1 mV |
| pack_v_i | input | W | Pack voltage, 10 mV |
| chg_temp_i | input | W | Charge-side temperature, 0.1 K |
| dsg_temp_i | input | W | Discharge-side temperature, 0.1 K |
| pack_cur_i | input | W | Signed pack current, 10 mA, negative = discharge |
| short_det_i | input | 1 | Short-circuit detect |
| afe_fault_i | input | 1 | Front-end error |
| trip_thr_i | input | 8*W | Trip thresholds for faults 0..7 |
| rel_thr_i | input | 8*W | Release thresholds for faults 0..7 |
| pair_dly_i | input | 4*2*DLY_W | Release delays, per pair: low byte under, high byte over |
| oc_chg_thr_i | input | W | Signed charge overcurrent threshold |
| oc_dsg_thr_i | input | W | Signed discharge overcurrent threshold |
| oc_chg_dly_i | input | 2*DLY_W | Charge overcurrent: low trip delay, high release delay |
| oc_dsg_dly_i | input | 2*DLY_W | Discharge overcurrent: low trip delay, high release delay |
| sc_rel_dly_i | input | DLY_W | Short-circuit release delay |
| fet_off_i | input | 2 | Switch block: bit 0 charge, bit 1 discharge |
| cnt_clr_i | input | 1 | Clear all event counters |
| status_o | output | 13 | Fault status word |
| chg_en_o | output | 1 | Charge permit |
| dsg_en_o | output | 1 | Discharge permit |
| evt_cnt_o | output | 11*CNT_W | Event counters, slot k for status bit k |

## Verification
The counter clear and a new fault trip can land on the same edge. The bench raises the short-circuit detect and the clear strobe on the same cycle. It expects the short-circuit counter to read 1 and every other counter to read 0. A re-trip can also coincide with a release countdown in progress. It is provoked by pushing the cell voltage back above trip while the delay runs, and the bench expects the bit to stay set for the full delay again. A behavioural model compares the status word, both permits and all counters on every clock.

// File: rtl/prot_fault_pkg.sv
package prot_fault_pkg;
  localparam int NUM_FLT = 13;
  localparam int NUM_CNT = 11;
  localparam int NUM_HYS = 8;
  localparam int NUM_SRC = 5;
  localparam int FB_CHG_OC = 8;
  localparam int FB_DSG_OC = 9;
  localparam int FB_SHORT  = 10;
  localparam int FB_AFE    = 11;
  localparam int FB_LOCK   = 12;
  // bits 0,2,4,5,8,10 block charge; bits 1,3,6,7,9,10 block discharge
  localparam logic [NUM_FLT-1:0] CHG_BLOCK = 13'h0535;
  localparam logic [NUM_FLT-1:0] DSG_BLOCK = 13'h06CA;
endpackage

// File: rtl/thr_cmp.sv
module thr_cmp #(
  parameter int W    = 16,
  parameter bit OVER = 1'b1
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] trip_i,
  input  logic [W-1:0] rel_i,
  output logic         trip_o,
  output logic         rel_o
);
  generate
    if (OVER) begin : g_over
      assign trip_o = (val_i > trip_i);
      assign rel_o  = (val_i < rel_i);
    end else begin : g_under
      assign trip_o = (val_i < trip_i);
      assign rel_o  = (val_i > rel_i);
    end
  endgenerate
endmodule

// File: rtl/fault_chan.sv
module fault_chan #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             trip_c_i,
  input  logic             rel_c_i,
  input  logic [DLY_W-1:0] trip_dly_i,
  input  logic [DLY_W-1:0] rel_dly_i,
  output logic             flt_o,
  output logic             set_o
);
  logic             flt_q, flt_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    flt_d = flt_q;
    cnt_d = cnt_q;
    if (!flt_q) begin
      if (trip_c_i) begin
        if (cnt_q >= trip_dly_i) begin
          flt_d = 1'b1;
          cnt_d = rel_dly_i;
        end else if (tick_i) begin
          cnt_d = cnt_q + DLY_W'(1);
        end
      end else begin
        cnt_d = '0;
      end
    end else begin
      if (trip_c_i) begin
        cnt_d = rel_dly_i;
      end else if (rel_c_i) begin
        if (cnt_q == '0) flt_d = 1'b0;
        else if (tick_i) cnt_d = cnt_q - DLY_W'(1);
      end else begin
        cnt_d = rel_dly_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign flt_o = flt_q;
  assign set_o = flt_d & ~flt_q;

  AST_SET_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(trip_c_i)); // R1
  AST_CLR_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> ($past(rel_c_i) && ($past(cnt_q) == '0))); // R3
  AST_RETRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && trip_c_i) |=> flt_q); // R4
endmodule

// File: rtl/evt_ctr.sv
module evt_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) cnt_d = {{(CNT_W-1){1'b0}}, evt_i};
    else if (evt_i && (cnt_q != '1)) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '1) && !clr_i) |=> (cnt_q == '1)); // R9
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/prot_fault_mon.sv
module prot_fault_mon
  import prot_fault_pkg::*;
#(
  parameter int W     = 16,
  parameter int DLY_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_i,
  input  logic [W-1:0]                cell_max_i,
  input  logic [W-1:0]                cell_min_i,
  input  logic [W-1:0]                pack_v_i,
  input  logic [W-1:0]                chg_temp_i,
  input  logic [W-1:0]                dsg_temp_i,
  input  logic signed [W-1:0]         pack_cur_i,
  input  logic                        short_det_i,
  input  logic                        afe_fault_i,
  input  logic [NUM_HYS*W-1:0]        trip_thr_i,
  input  logic [NUM_HYS*W-1:0]        rel_thr_i,
  input  logic [NUM_HYS*DLY_W-1:0]    pair_dly_i,
  input  logic signed [W-1:0]         oc_chg_thr_i,
  input  logic signed [W-1:0]         oc_dsg_thr_i,
  input  logic [2*DLY_W-1:0]          oc_chg_dly_i,
  input  logic [2*DLY_W-1:0]          oc_dsg_dly_i,
  input  logic [DLY_W-1:0]            sc_rel_dly_i,
  input  logic [1:0]                  fet_off_i,
  input  logic                        cnt_clr_i,
  output logic [NUM_FLT-1:0]          status_o,
  output logic                        chg_en_o,
  output logic                        dsg_en_o,
  output logic [NUM_CNT*CNT_W-1:0]    evt_cnt_o
);
  localparam int PAIR_W = 2 * DLY_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  logic [W-1:0]         src_v [NUM_SRC];
  logic [NUM_CNT-1:0]   flt, set_ev, trip_c, rel_c;
  logic [DLY_W-1:0]     trip_dly [NUM_CNT];
  logic [DLY_W-1:0]     rel_dly  [NUM_CNT];

  assign src_v[0] = cell_max_i;
  assign src_v[1] = cell_min_i;
  assign src_v[2] = pack_v_i;
  assign src_v[3] = chg_temp_i;
  assign src_v[4] = dsg_temp_i;

  genvar k;
  generate
    for (k = 0; k < NUM_HYS; k++) begin : g_hys
      localparam int  SRC  = (k < 2) ? k : (k / 2) + 1;
      localparam bit  OVER = ((k % 2) == 0);
      localparam int  DOFS = (k / 2) * PAIR_W + (OVER ? DLY_W : 0);
      thr_cmp #(.W(W), .OVER(OVER)) u_cmp (
        .val_i (src_v[SRC]),
        .trip_i(trip_thr_i[k*W +: W]),
        .rel_i (rel_thr_i[k*W +: W]),
        .trip_o(trip_c[k]),
        .rel_o (rel_c[k])
      );
      assign trip_dly[k] = '0;
      assign rel_dly[k]  = pair_dly_i[DOFS +: DLY_W];
    end
  endgenerate

  assign trip_c[FB_CHG_OC]   = (pack_cur_i > oc_chg_thr_i);
  assign rel_c[FB_CHG_OC]    = ~trip_c[FB_CHG_OC];
  assign trip_dly[FB_CHG_OC] = oc_chg_dly_i[0 +: DLY_W];
  assign rel_dly[FB_CHG_OC]  = oc_chg_dly_i[DLY_W +: DLY_W];

  assign trip_c[FB_DSG_OC]   = (pack_cur_i < oc_dsg_thr_i);
  assign rel_c[FB_DSG_OC]    = ~trip_c[FB_DSG_OC];
  assign trip_dly[FB_DSG_OC] = oc_dsg_dly_i[0 +: DLY_W];
  assign rel_dly[FB_DSG_OC]  = oc_dsg_dly_i[DLY_W +: DLY_W];

  assign trip_c[FB_SHORT]    = short_det_i;
  assign rel_c[FB_SHORT]     = ~short_det_i;
  assign trip_dly[FB_SHORT]  = '0;
  assign rel_dly[FB_SHORT]   = sc_rel_dly_i;

  generate
    for (k = 0; k < NUM_CNT; k++) begin : g_chan
      fault_chan #(.DLY_W(DLY_W)) u_chan (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .tick_i    (tick_i),
        .trip_c_i  (trip_c[k]),
        .rel_c_i   (rel_c[k]),
        .trip_dly_i(trip_dly[k]),
        .rel_dly_i (rel_dly[k]),
        .flt_o     (flt[k]),
        .set_o     (set_ev[k])
      );
      evt_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_int_n),
        .evt_i(set_ev[k]),
        .clr_i(cnt_clr_i),
        .cnt_o(evt_cnt_o[k*CNT_W +: CNT_W])
      );
    end
  endgenerate

  // mirrored inputs
  logic       afe_q, afe_d;
  logic [1:0] fet_q, fet_d;

  always_comb begin
    afe_d = afe_fault_i;
    fet_d = fet_off_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      afe_q <= 1'b0;
      fet_q <= 2'b00;
    end else begin
      afe_q <= afe_d;
      fet_q <= fet_d;
    end
  end

  assign status_o = {(|fet_q), afe_q, flt};
  assign chg_en_o = ~(|(status_o & CHG_BLOCK)) & ~fet_q[0];
  assign dsg_en_o = ~(|(status_o & DSG_BLOCK)) & ~fet_q[1];

  AST_LOCK_FLAGS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fet_off_i != 2'b00) |=> status_o[FB_LOCK]); // R7
  AST_DSG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    fet_off_i[1] |=> !dsg_en_o); // R7
  AST_SHORT_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    short_det_i |=> (!chg_en_o && !dsg_en_o)); // R8
endmodule

// File: tb/prot_fault_mon_tb.sv
module prot_fault_mon_tb;
  localparam int W  = 16;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [W-1:0] cell_max, cell_min, pack_v, chg_t, dsg_t;
  logic signed [W-1:0] cur, oc_chg_thr, oc_dsg_thr;
  logic short_det, afe, cnt_clr;
  logic [8*W-1:0] trip_thr, rel_thr;
  logic [8*DW-1:0] pair_dly;
  logic [2*DW-1:0] oc_chg_dly, oc_dsg_dly;
  logic [DW-1:0] sc_rel;
  logic [1:0] fet_off;
  logic [12:0] status;
  logic chg_en, dsg_en;
  logic [11*CW-1:0] evt_cnt;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  prot_fault_mon #(.W(W), .DLY_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cell_max_i(cell_max), .cell_min_i(cell_min), .pack_v_i(pack_v),
    .chg_temp_i(chg_t), .dsg_temp_i(dsg_t), .pack_cur_i(cur),
    .short_det_i(short_det), .afe_fault_i(afe),
    .trip_thr_i(trip_thr), .rel_thr_i(rel_thr), .pair_dly_i(pair_dly),
    .oc_chg_thr_i(oc_chg_thr), .oc_dsg_thr_i(oc_dsg_thr),
    .oc_chg_dly_i(oc_chg_dly), .oc_dsg_dly_i(oc_dsg_dly),
    .sc_rel_dly_i(sc_rel), .fet_off_i(fet_off), .cnt_clr_i(cnt_clr),
    .status_o(status), .chg_en_o(chg_en), .dsg_en_o(dsg_en),
    .evt_cnt_o(evt_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_flt [11];
  int m_cnt [11];
  int m_evc [11];
  int m_afe;
  int m_fet;
  int rs_pipe;

  function automatic void conds(input int k, output bit tr, output bit rl,
                                output int td, output int rd);
    int v, t, r;
    tr = 0; rl = 0; td = 0; rd = 0;
    if (k < 8) begin
      case (k)
        0: v = cell_max;
        1: v = cell_min;
        2, 3: v = pack_v;
        4, 5: v = chg_t;
        default: v = dsg_t;
      endcase
      t = trip_thr[k*W +: W];
      r = rel_thr[k*W +: W];
      if (k % 2 == 0) begin tr = v > t; rl = v < r; rd = pair_dly[(k/2)*16+8 +: 8]; end
      else            begin tr = v < t; rl = v > r; rd = pair_dly[(k/2)*16 +: 8]; end
    end else if (k == 8) begin
      tr = int'(cur) > int'(oc_chg_thr); rl = !tr;
      td = oc_chg_dly[7:0]; rd = oc_chg_dly[15:8];
    end else if (k == 9) begin
      tr = int'(cur) < int'(oc_dsg_thr); rl = !tr;
      td = oc_dsg_dly[7:0]; rd = oc_dsg_dly[15:8];
    end else begin
      tr = short_det; rl = !short_det; rd = sc_rel;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 11; k++) begin m_flt[k] = 0; m_cnt[k] = 0; m_evc[k] = 0; end
      m_afe = 0; m_fet = 0; rs_pipe = 0;
    end else begin
      if (rs_pipe >= 2) begin
        for (int k = 0; k < 11; k++) begin
          bit tr, rl, ev;
          int td, rd;
          conds(k, tr, rl, td, rd);
          ev = 0;
          if (m_flt[k] == 0) begin
            if (tr) begin
              if (m_cnt[k] >= td) begin m_flt[k] = 1; m_cnt[k] = rd; ev = 1; end
              else if (tick) m_cnt[k]++;
            end else m_cnt[k] = 0;
          end else begin
            if (tr) m_cnt[k] = rd;
            else if (rl) begin
              if (m_cnt[k] == 0) m_flt[k] = 0;
              else if (tick) m_cnt[k]--;
            end else m_cnt[k] = rd;
          end
          if (cnt_clr) m_evc[k] = ev ? 1 : 0;
          else if (ev && m_evc[k] < CMAX) m_evc[k]++;
        end
        m_afe = afe;
        m_fet = fet_off;
      end
      if (rs_pipe < 2) rs_pipe++;
    end
  end

  function automatic int exp_status();
    int s;
    s = 0;
    for (int k = 0; k < 11; k++) if (m_flt[k] != 0) s |= (1 << k);
    if (m_afe != 0) s |= (1 << 11);
    if (m_fet != 0) s |= (1 << 12);
    return s;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      int s, ce, de;
      s  = exp_status();
      ce = ((s & 32'h0535) == 0 && (m_fet & 1) == 0) ? 1 : 0;
      de = ((s & 32'h06CA) == 0 && (m_fet & 2) == 0) ? 1 : 0;
      chk(int'(status) == s, "R1 status", int'(status), s);
      chk(int'(chg_en) == ce && int'(dsg_en) == de, "R8 enables",
          int'({chg_en, dsg_en}), ce * 2 + de);
      for (int k = 0; k < 11; k++)
        chk(int'(evt_cnt[k*CW +: CW]) == m_evc[k], "R9 counter",
            int'(evt_cnt[k*CW +: CW]), m_evc[k]);
    end
    tick <= (cyc % 8 == 7);
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_trip(input int k, input int t, input int r);
    trip_thr[k*W +: W] = W'(t);
    rel_thr[k*W +: W]  = W'(r);
  endtask

  initial begin
    cell_max = 16'd3600; cell_min = 16'd3500; pack_v = 16'd4800;
    chg_t = 16'd2980; dsg_t = 16'd2980; cur = 16'sd0;
    short_det = 0; afe = 0; cnt_clr = 0; fet_off = 2'b00;
    trip_thr = '0; rel_thr = '0;
    set_trip(0, 4200, 4100); set_trip(1, 2800, 3000);
    set_trip(2, 5400, 5300); set_trip(3, 4000, 4200);
    set_trip(4, 3180, 3130); set_trip(5, 2730, 2780);
    set_trip(6, 3330, 3230); set_trip(7, 2530, 2580);
    pair_dly = {16'h0000, 16'h0201, 16'h0100, 16'h0302};
    oc_chg_thr = 16'sd500; oc_dsg_thr = -16'sd800;
    oc_chg_dly = 16'h0201; oc_dsg_dly = 16'h0100;
    sc_rel = 8'd2;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R11 reset state
    chk(status == 13'd0 && evt_cnt == '0, "R11", int'(status), 0);
    chk(chg_en && dsg_en, "R11 enables", int'({chg_en, dsg_en}), 3);

    // R1 boundary then trip
    cell_max = 16'd4200; wait_cyc(2);
    chk(status[0] == 1'b0, "R1 equal to trip", int'(status[0]), 0);
    cell_max = 16'd4201; wait_cyc(1);
    chk(status[0] == 1'b1, "R1 over trip", int'(status[0]), 1);
    chk(chg_en == 1'b0 && dsg_en == 1'b1, "R8 cell over", int'({chg_en, dsg_en}), 1);
    // R2 band and equal to release hold the fault
    cell_max = 16'd4150; wait_cyc(40);
    chk(status[0] == 1'b1, "R2 band", int'(status[0]), 1);
    cell_max = 16'd4100; wait_cyc(40);
    chk(status[0] == 1'b1, "R2 equal release", int'(status[0]), 1);
    // R4 re-trip while delay runs
    cell_max = 16'd4099; wait_cyc(12);
    cell_max = 16'd4300; wait_cyc(1);
    cell_max = 16'd4000; wait_cyc(16);
    chk(status[0] == 1'b1, "R4 restart", int'(status[0]), 1);
    wait_cyc(30);
    chk(status[0] == 1'b0, "R3 release delay", int'(status[0]), 0);
    chk(evt_cnt[0 +: CW] == CW'(1), "R9 one event", int'(evt_cnt[0 +: CW]), 1);

    // R3 under fault with low-byte delay
    cell_min = 16'd2799; wait_cyc(1);
    chk(status[1] && !dsg_en, "R1 cell under", int'(status[1]), 1);
    cell_min = 16'd3100; wait_cyc(40);
    chk(status[1] == 1'b0, "R3 under released", int'(status[1]), 0);

    // pack and temperature channels
    pack_v = 16'd5401; wait_cyc(3); pack_v = 16'd4800; wait_cyc(30);
    pack_v = 16'd3999; wait_cyc(1);
    chk(status[3] == 1'b1, "R1 pack under", int'(status[3]), 1);
    pack_v = 16'd4800; wait_cyc(2);
    chk(status[3] == 1'b0, "R3 zero delay", int'(status[3]), 0);
    chg_t = 16'd3181; wait_cyc(3); chg_t = 16'd2980; wait_cyc(40);
    chg_t = 16'd2729; wait_cyc(3); chg_t = 16'd2980; wait_cyc(40);
    dsg_t = 16'd3331; wait_cyc(1);
    chk(status[6] && !dsg_en && chg_en, "R8 dsg overtemp", int'({chg_en, dsg_en}), 2);
    dsg_t = 16'd2980; wait_cyc(3);
    dsg_t = 16'd2529; wait_cyc(3); dsg_t = 16'd2980; wait_cyc(5);

    // R5 overcurrent
    cur = 16'sd500; wait_cyc(30);
    chk(status[8] == 1'b0, "R5 chg at threshold", int'(status[8]), 0);
    cur = 16'sd501; wait_cyc(30);
    chk(status[8] == 1'b1, "R5 chg overcurrent", int'(status[8]), 1);
    cur = -16'sd801; wait_cyc(1);
    chk(status[9] == 1'b1, "R5 dsg overcurrent", int'(status[9]), 1);
    cur = 16'sd0; wait_cyc(40);
    chk(status[9:8] == 2'b00, "R5 released", int'(status[9:8]), 0);

    // R6 short circuit and front-end error
    short_det = 1; wait_cyc(1);
    chk(status[10] && !chg_en && !dsg_en, "R6 short", int'(status[10]), 1);
    short_det = 0; wait_cyc(40);
    afe = 1; wait_cyc(1);
    chk(status[11] == 1'b1, "R6 afe", int'(status[11]), 1);
    afe = 0; wait_cyc(1);

    // R7 switch lock
    fet_off = 2'b01; wait_cyc(1);
    chk(status[12] && !chg_en && dsg_en, "R7 charge block", int'({chg_en, dsg_en}), 1);
    fet_off = 2'b10; wait_cyc(1);
    chk(status[12] && chg_en && !dsg_en, "R7 discharge block", int'({chg_en, dsg_en}), 2);
    fet_off = 2'b00; wait_cyc(1);

    // R10 clear coincides with a new trip
    short_det = 1; cnt_clr = 1; wait_cyc(1);
    cnt_clr = 0;
    chk(evt_cnt[10*CW +: CW] == CW'(1), "R10 clear with event",
        int'(evt_cnt[10*CW +: CW]), 1);
    chk(evt_cnt[0 +: CW] == '0, "R10 cleared slot", int'(evt_cnt[0 +: CW]), 0);
    short_det = 0; wait_cyc(40);

    // R9 saturation
    for (int i = 0; i < 9; i++) begin
      short_det = 1; wait_cyc(1); short_det = 0; wait_cyc(30);
    end
    chk(evt_cnt[10*CW +: CW] == CW'(CMAX), "R9 saturate",
        int'(evt_cnt[10*CW +: CW]), CMAX);

    cnt_clr = 1; wait_cyc(1); cnt_clr = 0;
    chk(evt_cnt == '0, "R10 clear all", int'(evt_cnt), 0);
    wait_cyc(4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule